// File: doc/BRIEF.md
# Sequential Binary-to-Decimal Converter

This block turns a 16-bit unsigned binary number into five packed decimal digits. The method is the classic shift-and-add-3 algorithm, one input bit per clock. A caller presents a value together with a one-cycle start strobe. The block raises busy for the length of the conversion and then pulses done for one cycle. The packed result then stays on the output until the next accepted start.

The result sits in a 24-bit register made of three bytes. The ten-thousands digit occupies the low nibble of the top byte, and the top nibble is always zero. After each shift except the last, every nibble of the result chain is tested and corrected. A nibble gets 3 added when the sum has its bit 3 set, which is the case when the nibble is 5 or more. The sixteenth shift receives no correction, and the conversion ends on that shift.

Top module: `bin_to_bcd_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy_o` and `done_o` are 0 and `bcd_o` is 0x000000.
- R2: A start strobe seen while `busy_o` is low is accepted. In the following cycle `busy_o` is 1 and `bcd_o` reads 0x000000, because the result register is cleared.
- R3: An accepted conversion keeps `busy_o` high for exactly 16 cycles. In the first cycle with `busy_o` low again, `done_o` is 1 for that one cycle only. `done_o` is never high together with `busy_o`.
- R4: When a conversion completes, `bcd_o` holds the decimal form of the accepted value. Digit k (units k=0 up to ten-thousands k=4) sits in bits 4k+3..4k, and bits 23..20 are 0.
- R5: A start strobe, or a change of `bin_i`, while `busy_o` is high has no effect on the running conversion or on its result.
- R6: While `busy_o` is low and no start is accepted, `bcd_o` keeps its value from cycle to cycle.
- R7: The inputs 0, 54321 and 65535 produce 0x000000, 0x054321 and 0x065535 respectively.
- R8: Whenever `busy_o` is low, every nibble of `bcd_o` is in the range 0..9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| bin_i | input | 16 | Unsigned binary value, sampled with an accepted start |
| busy_o | output | 1 | High while a conversion runs |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| bcd_o | output | 24 | Packed decimal result, three bytes |

## Verification
The assertions assume that `start_i` and `bin_i` change only between clock edges. They also assume that a caller may raise `start_i` at any time, including while busy and in the cycle that carries done. The digit-range and hold properties rely on the converted value never exceeding 16 bits, which the port width enforces. The stimulus drives inputs on the falling edge. It covers back-to-back starts issued in the done cycle and deliberate strobes with a different value in the middle of a conversion. It also sweeps random values as well as the extreme values.

// File: rtl/bcd_conv_pkg.sv
package bcd_conv_pkg;
  localparam int NIB_W = 4;
  localparam int BYTE_W = 8;

  typedef enum logic {
    CONV_IDLE = 1'b0,
    CONV_RUN  = 1'b1
  } conv_state_e;
endpackage

// File: rtl/bcd_nib_adj.sv
module bcd_nib_adj
  import bcd_conv_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  output logic [NIB_W-1:0] nib_o
);
  logic [NIB_W-1:0] plus3;

  always_comb begin
    plus3 = nib_i + NIB_W'(3);
    nib_o = plus3[NIB_W-1] ? plus3 : nib_i;
  end
endmodule

// File: rtl/bcd_iter_ctrl.sv
module bcd_iter_ctrl
  import bcd_conv_pkg::*;
#(
  parameter int ITER = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(ITER + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ITER - 1);

  conv_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_comb begin
    load_o = (state_q == CONV_IDLE) && start_i;
    step_o = (state_q == CONV_RUN);
    last_o = step_o && (cnt_q == LAST_IDX);
    busy_o = (state_q == CONV_RUN);
    done_o = done_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CONV_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        state_q <= CONV_RUN;
        cnt_q   <= '0;
      end else if (step_o) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (last_o) begin
          state_q <= CONV_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bcd_shift_path.sv
module bcd_shift_path
  import bcd_conv_pkg::*;
#(
  parameter int BIN_W = 16,
  parameter int RES_BYTES = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load_i,
  input  logic                          step_i,
  input  logic                          last_i,
  input  logic [BIN_W-1:0]              bin_i,
  output logic [RES_BYTES*BYTE_W-1:0]   res_o
);
  localparam int RES_W = RES_BYTES * BYTE_W;
  localparam int NIBS  = RES_W / NIB_W;

  logic [BIN_W-1:0] bin_q;
  logic [RES_W-1:0] res_q;
  logic [RES_W-1:0] shifted;
  logic [RES_W-1:0] adjusted;

  assign shifted = {res_q[RES_W-2:0], bin_q[BIN_W-1]};

  for (genvar n = 0; n < NIBS; n++) begin : g_nib
    bcd_nib_adj u_adj (
      .nib_i(shifted[n*NIB_W +: NIB_W]),
      .nib_o(adjusted[n*NIB_W +: NIB_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bin_q <= '0;
      res_q <= '0;
    end else if (load_i) begin
      bin_q <= bin_i;
      res_q <= '0;
    end else if (step_i) begin
      bin_q <= {bin_q[BIN_W-2:0], 1'b0};
      res_q <= last_i ? shifted : adjusted;
    end
  end

  assign res_o = res_q;
endmodule

// File: rtl/bin_to_bcd_seq.sv
module bin_to_bcd_seq
  import bcd_conv_pkg::*;
#(
  parameter int BIN_W = 16,
  parameter int RES_BYTES = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_i,
  input  logic [BIN_W-1:0]            bin_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [RES_BYTES*8-1:0]      bcd_o
);
  logic load, step, last;

  bcd_iter_ctrl #(.ITER(BIN_W)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i),
    .load_o(load), .step_o(step), .last_o(last),
    .busy_o(busy_o), .done_o(done_o)
  );

  bcd_shift_path #(.BIN_W(BIN_W), .RES_BYTES(RES_BYTES)) u_path (
    .clk(clk), .rst(rst), .load_i(load), .step_i(step), .last_i(last),
    .bin_i(bin_i), .res_o(bcd_o)
  );
endmodule

// File: rtl/bcd_conv_checker.sv
module bcd_conv_checker #(
  parameter int ITER = 16,
  parameter int RES_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [RES_W-1:0] bcd_o
);
  localparam int CW = $clog2(ITER + 2);
  logic [CW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst || !busy_o) run_len <= '0;
    else                run_len <= run_len + CW'(1);
  end

  function automatic logic all_decimal(input logic [RES_W-1:0] v);
    logic ok = 1'b1;
    for (int i = 0; i < RES_W / 4; i++) if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst) (start_i && !busy_o) |=> busy_o); // R2
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst) (start_i && !busy_o) |=> (bcd_o == '0)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done_o |-> !busy_o); // R3
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst) $fell(busy_o) |-> done_o); // R3
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst) $fell(busy_o) |-> (run_len == CW'(ITER))); // R3
  AST_TOP_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (rst) !busy_o |-> (bcd_o[RES_W-1 -: 4] == 4'd0)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!busy_o && !start_i) |=> $stable(bcd_o)); // R6
  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst) !busy_o |-> all_decimal(bcd_o)); // R8
endmodule

bind bin_to_bcd_seq bcd_conv_checker #(.ITER(BIN_W), .RES_W(RES_BYTES*8)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .bcd_o(bcd_o)
);

// File: tb/sim_bin_to_bcd_seq.sv
module sim_bin_to_bcd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] bin_i = '0;
  logic        busy_o, done_o;
  logic [23:0] bcd_o;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit finished = 0;

  bin_to_bcd_seq u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .bin_i(bin_i),
    .busy_o(busy_o), .done_o(done_o), .bcd_o(bcd_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] to_dec(input int v);
    logic [23:0] r = '0;
    int x = v;
    for (int k = 0; k < 5; k++) begin
      r[k*4 +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  // behavioural reference
  bit          m_busy = 0, m_done = 0, m_fresh = 0;
  int          m_left = 0;
  int          m_val = 0;
  logic [23:0] m_res = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_busy <= 0; m_done <= 0; m_fresh <= 0; m_res <= '0; m_left <= 0;
    end else begin
      m_done  <= 0;
      m_fresh <= 0;
      if (start_i && !m_busy) begin
        m_busy <= 1; m_left <= 16; m_val <= int'(bin_i); m_res <= '0; m_fresh <= 1;
      end else if (m_busy) begin
        m_left <= m_left - 1;
        if (m_left == 1) begin
          m_busy <= 0; m_done <= 1; m_res <= to_dec(m_val);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %06h expected %06h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      check("R1 busy in reset", 24'(busy_o), 24'(0));
      check("R1 done in reset", 24'(done_o), 24'(0));
      check("R1 result in reset", bcd_o, 24'h0);
    end else if (!finished) begin
      check("R3 busy", 24'(busy_o), 24'(m_busy));
      check("R3 done", 24'(done_o), 24'(m_done));
      if (m_fresh) check("R2 cleared on start", bcd_o, 24'h0);
      else if (!m_busy) check("R4/R6 result", bcd_o, m_res);
      if (m_done) begin
        for (int k = 0; k < 6; k++) begin
          compared++;
          if (bcd_o[k*4 +: 4] > 4'd9) begin
            mismatched++;
            $display("FAIL R8 nibble %0d: actual %0d expected <=9", k, bcd_o[k*4 +: 4]);
          end
        end
      end
    end
  end

  task automatic convert(input logic [15:0] v, input bit meddle);
    @(negedge clk);
    start_i = 1'b1; bin_i = v;
    @(negedge clk);
    start_i = 1'b0; bin_i = ~v;
    if (meddle) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1; bin_i = v ^ 16'h5a5a;  // R5: must be ignored
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", bcd_o, 24'h0);

    convert(16'd54321, 0); check("R7 54321", bcd_o, 24'h054321);
    convert(16'd0, 0);     check("R7 zero", bcd_o, 24'h000000);
    convert(16'd65535, 0); check("R7 65535", bcd_o, 24'h065535);
    convert(16'd9999, 1);  check("R5 ignored start", bcd_o, 24'h009999);
    convert(16'd10000, 1); check("R5 ignored start 2", bcd_o, 24'h010000);

    // R6: idle with changing bin_i
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); bin_i = 16'(i * 777);
    end
    check("R6 hold", bcd_o, 24'h010000);

    // back-to-back start on the done cycle
    @(negedge clk); start_i = 1'b1; bin_i = 16'd4095;
    @(negedge clk); start_i = 1'b0;
    while (!done_o) @(negedge clk);
    start_i = 1'b1; bin_i = 16'd12345;
    @(negedge clk); start_i = 1'b0;
    while (!done_o) @(negedge clk);
    check("R4 back-to-back", bcd_o, 24'h012345);

    for (int i = 0; i < 300; i++) begin
      logic [15:0] v = 16'($urandom);
      convert(v, i[0]);
      check("R4 random", bcd_o, to_dec(int'(v)));
    end

    repeat (2) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > MAX_CYC && !finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected <= %0d", cyc, MAX_CYC);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule